// File: doc/BRIEF.md
# Polarity-Programmable Bidirectional GPIO Bank

This block is a bank of general-purpose I/O bits. Each bit carries a small configuration register that holds a direction flag and a polarity flag. One shared data register, one bit per GPIO, is visible to the host. The host reaches every register through a 4-bit address, an 8-bit data bus, and single-cycle read and write strobes. Reads answer one clock after the strobe.

A bit set as an input does not drive its pad. A host read of the data register samples the synchronized pin level, inverted when polarity is set. Writes to that bit are discarded. A bit set as an output drives its stored data value onto the pad, inverted when polarity is set. A host read of that bit returns the stored value, not the pin. Each pad gets an output value and an output enable, which go to an external tri-state buffer.

The host bus is a plain strobed register interface with no back-pressure. A strobe is accepted in the cycle it is high. The read result appears on the next cycle together with a one-cycle valid pulse, and it stays on the bus until the next read.

Top module: `gpio_polar_bank`

## Requirements
- R1: After reset every bit is an input with non-inverted polarity, and the data register is zero. Every `pad_oe` bit is 0, `pad_out` is 0 and `rd_valid` is 0.
- R2: The register map works as follows.
  - Address 0 is the data register, bit i for GPIO i.
  - Address 1+i is the configuration register of GPIO i. Bit 0 is direction (1 = output) and bit 1 is polarity (1 = inverted).
  - Configuration bits 7:2 read as 0 and are not stored.
  - Addresses above NUM_BITS read as 0, and writes to them change nothing.
- R3: For an input bit, a read of address 0 returns the pin level XOR the polarity bit. The pin level used is the one present at the clock edge two edges before the edge that accepts the read strobe, because of a two-flop synchronizer.
- R4: For an input bit, a write to address 0 leaves the stored data bit unchanged. If the bit is later turned into an output, it drives its earlier stored value, not the value that was discarded.
- R5: For an output bit, `pad_out` equals the stored data bit XOR the polarity bit. A write to address 0 shows on `pad_out` one cycle after the write strobe.
- R6: For an output bit, a read of address 0 returns the last value written to that bit, whatever the pin level.
- R7: `pad_oe[i]` is 1 exactly when GPIO i's direction bit selects output.
- R8: `rd_valid` is high for exactly the one cycle after a read strobe. `rd_data` keeps its value until the next read strobe.
- R9: Changing the polarity bit of an output inverts `pad_out` on the next cycle without a new data write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_addr | input | 4 | Write register address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Single-cycle read strobe |
| rd_addr | input | 4 | Read register address |
| rd_data | output | 8 | Read result, registered |
| rd_valid | output | 1 | One-cycle pulse marking a fresh read result |
| pad_in | input | 8 | Pin levels from the pads, asynchronous |
| pad_out | output | 8 | Value to drive on each pad |
| pad_oe | output | 8 | Output enable per pad |

## Verification
The assertions take two things for granted.
- The reset is asserted long enough to clear the synchronizer.
- The strobes are plain level signals sampled on the rising edge, with no width limit.

The stimulus changes the strobes, addresses, write data and pin levels only just after the rising edge, so nothing moves at the sampling instant. It also mixes reads and writes in the same cycle, so the read result must reflect the state before that cycle's write. Pin levels change freely, including one cycle before a read, which exercises the two-cycle synchronizer latency. The per-cycle reference model tracks that latency exactly.

// File: rtl/gpio_polar_pkg.sv
package gpio_polar_pkg;
  // Per-bit configuration; packed so that {pol, dir} maps to register bits 1:0
  typedef struct packed {
    logic pol;  // 1 = invert both read and drive paths
    logic dir;  // 1 = output
  } gpio_cfg_t;

  localparam int DATA_ADDR = 0;
  localparam int CFG_BASE  = 1;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] mid_q;
  logic [WIDTH-1:0] out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mid_q <= '0;
      out_q <= '0;
    end else begin
      mid_q <= d;
      out_q <= mid_q;
    end
  end

  assign q = out_q;

  AST_SYNC_SECOND_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> out_q == $past(mid_q)); // R3
endmodule

// File: rtl/gpio_bit_cell.sv
module gpio_bit_cell
  import gpio_polar_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [1:0] cfg_wdata,
  input  logic       data_we,
  input  logic       data_wbit,
  input  logic       pin_sync,
  output logic       pad_out,
  output logic       pad_oe,
  output logic       data_view,
  output gpio_cfg_t  cfg_view
);
  gpio_cfg_t cfg_q;
  logic      data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_we) begin
      cfg_q <= gpio_cfg_t'(cfg_wdata);
    end
  end

  // Writes only land while the bit is an output
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= 1'b0;
    end else if (data_we && cfg_q.dir) begin
      data_q <= data_wbit;
    end
  end

  assign pad_oe    = cfg_q.dir;
  assign pad_out   = data_q ^ cfg_q.pol;
  assign data_view = cfg_q.dir ? data_q : (pin_sync ^ cfg_q.pol);
  assign cfg_view  = cfg_q;

  AST_INPUT_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && !cfg_q.dir) |=> $stable(data_q)); // R4
  AST_OUTPUT_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && cfg_q.dir && !cfg_we) |=> pad_out == ($past(data_wbit) ^ cfg_q.pol)); // R5
  AST_POL_FLIPS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !data_we && (cfg_wdata[1] != cfg_q.pol)) |=> pad_out != $past(pad_out)); // R9
endmodule

// File: rtl/gpio_polar_bank.sv
module gpio_polar_bank
  import gpio_polar_pkg::*;
#(
  parameter int NUM_BITS = 8,
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  input  logic [NUM_BITS-1:0] pad_in,
  output logic [NUM_BITS-1:0] pad_out,
  output logic [NUM_BITS-1:0] pad_oe
);
  localparam logic [ADDR_W-1:0] DATA_A   = ADDR_W'(DATA_ADDR);
  localparam logic [ADDR_W-1:0] LAST_CFG = ADDR_W'(CFG_BASE + NUM_BITS - 1);

  logic [NUM_BITS-1:0] pin_sync;
  logic [NUM_BITS-1:0] data_view;
  gpio_cfg_t           cfg_view [NUM_BITS];
  logic                data_we;
  logic [DATA_W-1:0]   rd_next;
  logic [DATA_W-1:0]   rd_q;
  logic                rv_q;

  gpio_sync #(.WIDTH(NUM_BITS)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pad_in),
    .q    (pin_sync)
  );

  assign data_we = wr_en && (wr_addr == DATA_A);

  for (genvar i = 0; i < NUM_BITS; i++) begin : g_bit
    logic cfg_we;
    assign cfg_we = wr_en && (wr_addr == ADDR_W'(CFG_BASE + i));

    gpio_bit_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we),
      .cfg_wdata(wr_data[1:0]),
      .data_we  (data_we),
      .data_wbit(wr_data[i]),
      .pin_sync (pin_sync[i]),
      .pad_out  (pad_out[i]),
      .pad_oe   (pad_oe[i]),
      .data_view(data_view[i]),
      .cfg_view (cfg_view[i])
    );
  end

  always_comb begin
    rd_next = '0;
    if (rd_addr == DATA_A) begin
      rd_next[NUM_BITS-1:0] = data_view;
    end
    for (int i = 0; i < NUM_BITS; i++) begin
      if (rd_addr == ADDR_W'(CFG_BASE + i)) begin
        rd_next[1:0] = cfg_view[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
      rv_q <= 1'b0;
    end else begin
      rv_q <= rd_en;
      if (rd_en) begin
        rd_q <= rd_next;
      end
    end
  end

  assign rd_data  = rd_q;
  assign rd_valid = rv_q;

  AST_RD_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid); // R8
  AST_RD_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (!rd_valid && $stable(rd_data))); // R8
  AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr > LAST_CFG) |=> rd_data == '0); // R2
  AST_OE_STABLE_NO_CFG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr != DATA_A && wr_addr <= LAST_CFG) |=> $stable(pad_oe)); // R7
endmodule

// File: tb/gpio_polar_bank_tb.sv
`timescale 1ns/1ps
module gpio_polar_bank_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [3:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       rd_valid;
  logic [7:0] pad_in = '0;
  logic [7:0] pad_out;
  logic [7:0] pad_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Behavioural reference state
  logic [7:0] m_dir = '0, m_pol = '0, m_data = '0;
  logic [7:0] m_pins [$];
  logic [7:0] m_rd = '0;
  logic       m_rv = 1'b0;

  always #2.5 clk = ~clk;

  gpio_polar_bank u_dut (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_valid(rd_valid),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Model update on each rising edge: read uses pre-edge state, pins delayed two edges
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dir = '0; m_pol = '0; m_data = '0; m_rd = '0; m_rv = 1'b0;
      m_pins = '{8'h00, 8'h00};
    end else begin
      logic [7:0] seen;
      seen = m_pins[0];
      m_rv = rd_en;
      if (rd_en) begin
        if (rd_addr == 0) m_rd = (m_dir & m_data) | (~m_dir & (seen ^ m_pol));
        else if (rd_addr <= 8) m_rd = {6'b0, m_pol[rd_addr-1], m_dir[rd_addr-1]};
        else m_rd = 8'h00;
      end
      if (wr_en) begin
        if (wr_addr == 0) m_data = (m_dir & wr_data) | (~m_dir & m_data);
        else if (wr_addr <= 8) begin
          m_dir[wr_addr-1] = wr_data[0];
          m_pol[wr_addr-1] = wr_data[1];
        end
      end
      void'(m_pins.pop_front());
      m_pins.push_back(pad_in);
    end
  end

  // Compare every cycle on the falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R7 pad_oe", pad_oe, m_dir);
      chk("R5 pad_out", pad_out, m_data ^ m_pol);
      chk("R8 rd_valid", {7'b0, rd_valid}, {7'b0, m_rv});
      chk("R3 rd_data", rd_data, m_rd);
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a);
    rd_en = 1'b1; rd_addr = a;
    tick();
    rd_en = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    m_pins = '{8'h00, 8'h00};
    pad_in = 8'h3C;
    #12;
    chk("R1 reset pad_oe", pad_oe, 8'h00);
    chk("R1 reset pad_out", pad_out, 8'h00);
    chk("R1 reset rd_valid", {7'b0, rd_valid}, 8'h00);
    rst_n = 1'b1;
    tick();
    rd(4'd5);
    chk("R1 reset cfg", rd_data, 8'h00);
    // R3: input read with pin level through the synchronizer
    pad_in = 8'hA5; tick(); tick(); tick();
    rd(4'd0);
    chk("R3 input read", rd_data, 8'hA5);
    wr(4'd1, 8'h02); wr(4'd2, 8'h02);
    rd(4'd0);
    chk("R3 inverted input read", rd_data, 8'hA6);
    // R3 latency: pin changes one edge before read is not yet seen
    pad_in = 8'h00; rd(4'd0);
    chk("R3 sync latency", rd_data, 8'hA6);
    // R4: writes to input bits are dropped
    wr(4'd0, 8'hFF);
    wr(4'd3, 8'h01);
    chk("R4 dropped write", pad_out & 8'h04, 8'h00);
    chk("R7 oe after dir", pad_oe, 8'h04);
    // R5: output drive
    wr(4'd0, 8'h04);
    chk("R5 drive", pad_out & 8'h04, 8'h04);
    // R9: polarity flip on output
    wr(4'd3, 8'h03);
    chk("R9 pol flip", pad_out & 8'h04, 8'h00);
    // R6: output read returns stored value, not pin
    pad_in = 8'h00; tick(); tick();
    rd(4'd0);
    chk("R6 output read", rd_data & 8'h04, 8'h04);
    // R2: map details
    rd(4'd3);
    chk("R2 cfg readback", rd_data, 8'h03);
    wr(4'd4, 8'hFC); rd(4'd4);
    chk("R2 cfg upper bits", rd_data, 8'h00);
    wr(4'd12, 8'hFF); rd(4'd12);
    chk("R2 unmapped read", rd_data, 8'h00);
    chk("R2 unmapped write", pad_oe, 8'h04);
    // R8: valid pulse and hold
    rd(4'd3);
    chk("R8 valid pulse", {7'b0, rd_valid}, 8'h01);
    tick();
    chk("R8 valid drop", {7'b0, rd_valid}, 8'h00);
    chk("R8 data hold", rd_data, 8'h03);
    // Random mixed traffic compared cycle by cycle
    for (int n = 0; n < 2000; n++) begin
      wr_en   = ($urandom_range(0, 2) == 0);
      wr_addr = 4'($urandom_range(0, 10));
      wr_data = 8'($urandom);
      rd_en   = ($urandom_range(0, 1) == 0);
      rd_addr = 4'($urandom_range(0, 10));
      if ($urandom_range(0, 3) == 0) pad_in = 8'($urandom);
      tick();
    end
    wr_en = 1'b0; rd_en = 1'b0;
    tick(); tick();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule